// File: doc/BRIEF.md
# Coherence command round-robin arbiter

This block sits between four request sources inside a memory-side cache controller and one flit-based output channel that carries coherence commands to the first-level caches. Each source can ask for a multicast command (toward a known set of sharers) or a broadcast command (toward every cache). The arbiter picks one source with rotating priority, captures that source's destination and line-index fields, and sends the command as two flits under a valid/ready handshake.

The four sources are, by index: 0 the fill-response path, 1 the atomic path, 2 the store path and 3 the configuration path. A multicast from the atomic or store path is an update command. A multicast from the fill-response or configuration path is an invalidate command. Every broadcast is an invalidate command. When the second flit is accepted, the served source receives a one-cycle acknowledge on the line that matches the request kind. On the cycle after that acknowledge, the source must drop the request or present its next entry.

Two event counters record how many update commands and how many invalidate commands have been granted.

Top module: `coh_cmd_arb`

## Requirements
- R1: After synchronous reset, `flit_valid`, `ack_mc` and `ack_bc` are low and both counters read zero. The last-served source is taken to be index 3, so index 0 has the highest priority.
- R2: When idle, the arbiter scans the sources cyclically, starting at the index one above the source served last. It grants the first source that has any request. The served source therefore drops to lowest priority.
- R3: Within the granted source, a multicast request (`mc_req` bit) is served before a broadcast request (`bc_req` bit).
- R4: A multicast from index 1 or 2 is an update. Any other multicast, and every broadcast, is an invalidate. Header bit 1 is 1 for an update and 0 for an invalidate.
- R5: The header flit (first flit, `flit_eop`=0) carries: bit 0, set to 1 for a broadcast and 0 for a multicast; bit 1, the update flag; bits [3:2], the source index; bits [4+DEST_W-1:4], the source's destination field. All higher bits are zero.
- R6: The second flit carries the line index in bits [LINE_W-1:0], with all higher bits zero, and has `flit_eop`=1.
- R7: A flit advances only in a cycle where `flit_valid` and `flit_ready` are both high. While `flit_ready` is low, `flit_data` and `flit_eop` hold steady.
- R8: In the cycle the second flit is accepted, exactly one bit of `ack_mc`/`ack_bc` goes high: the bit for the served source and the kind that was served. At all other times these outputs are low.
- R9: Granting an update command increments `upd_count` by one. Granting an invalidate command increments `inv_count` by one. The increment is visible in the cycle the header flit first appears.
- R10: The destination and line-index fields are captured when the grant is made. Changes on `cli_dest` or `cli_line` after the grant do not alter the flits of the command already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_req | input | 4 | Multicast request, one bit per source |
| bc_req | input | 4 | Broadcast request, one bit per source |
| cli_dest | input | 4 x DEST_W | Destination field of each source |
| cli_line | input | 4 x LINE_W | Line index of each source |
| flit_ready | input | 1 | Receiver accepts the current flit |
| flit_valid | output | 1 | Flit on `flit_data` is valid |
| flit_data | output | FLIT_W | Header or line-index flit |
| flit_eop | output | 1 | Last flit of the command |
| ack_mc | output | 4 | Multicast served, one-cycle pulse per source |
| ack_bc | output | 4 | Broadcast served, one-cycle pulse per source |
| upd_count | output | CNT_W | Granted update commands |
| inv_count | output | CNT_W | Granted invalidate commands |

## Verification
The bench covers the following corner cases:

- **Priority wrap.** It drives request patterns that make the scan pass index 3 and start again at index 0. A fixed-priority arbiter, or one that starts the scan at the served source itself, would grant the wrong source there.
- **Both kinds from one source.** It raises both request kinds on the same source. An arbiter that checks broadcast first would send a header with bit 0 set and pulse the wrong acknowledge.
- **Stall with changing inputs.** It holds `flit_ready` low for several cycles while rewriting the destination and line inputs. A design that does not capture the fields at grant would emit the new values. A design that ignores the handshake would move to the next flit early.
- **Update/invalidate mapping.** The final counter values expose any source whose multicast is mapped to the wrong command class.

// File: rtl/coh_arb_pkg.sv
package coh_arb_pkg;

    localparam int N_CLI = 4;
    localparam int CID_W = 2;

    typedef logic [CID_W-1:0] cli_t;

    localparam cli_t CL_FILL  = 2'd0;
    localparam cli_t CL_ATOM  = 2'd1;
    localparam cli_t CL_STORE = 2'd2;
    localparam cli_t CL_CFG   = 2'd3;

    // header bit positions
    localparam int HB_BC   = 0;
    localparam int HB_UPD  = 1;
    localparam int HB_CLI  = 2;
    localparam int HB_DEST = HB_CLI + CID_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HEAD,
        PH_BODY
    } phase_e;

    typedef struct packed {
        logic valid;
        cli_t cli;
        logic bcast;
        logic upd;
    } grant_t;

    // a multicast from the atomic or store path updates copies; all else invalidates
    function automatic logic mc_is_update(cli_t c);
        return (c == CL_ATOM) || (c == CL_STORE);
    endfunction

endpackage

// File: rtl/coh_rr_pick.sv
module coh_rr_pick
    import coh_arb_pkg::*;
(
    input  cli_t              last_cli,
    input  logic [N_CLI-1:0]  mc_req,
    input  logic [N_CLI-1:0]  bc_req,
    output grant_t            gnt
);

    cli_t idx;

    always_comb begin
        gnt = '0;
        idx = '0;
        // scan starts one above the last served source and wraps
        for (int i = 0; i < N_CLI; i++) begin
            idx = last_cli + CID_W'(i + 1);
            if (!gnt.valid && (mc_req[idx] || bc_req[idx])) begin
                gnt.valid = 1'b1;
                gnt.cli   = idx;
                gnt.bcast = !mc_req[idx];
            end
        end
        gnt.upd = gnt.valid && !gnt.bcast && mc_is_update(gnt.cli);
    end

endmodule

// File: rtl/coh_flit_ser.sv
module coh_flit_ser
    import coh_arb_pkg::*;
#(
    parameter int DEST_W = 8,
    parameter int LINE_W = 26,
    parameter int FLIT_W = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  grant_t            gnt,
    input  logic [DEST_W-1:0] dest_in,
    input  logic [LINE_W-1:0] line_in,
    input  logic              flit_ready,
    output logic              idle,
    output logic              done,
    output cli_t              last_cli,
    output cli_t              srv_cli,
    output logic              srv_bc,
    output logic              flit_valid,
    output logic [FLIT_W-1:0] flit_data,
    output logic              flit_eop
);

    phase_e            ph;
    logic              cur_upd;
    logic [DEST_W-1:0] cur_dest;
    logic [LINE_W-1:0] cur_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= PH_IDLE;
            last_cli <= CL_CFG;
            srv_cli  <= '0;
            srv_bc   <= 1'b0;
            cur_upd  <= 1'b0;
            cur_dest <= '0;
            cur_line <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (gnt.valid) begin
                        ph       <= PH_HEAD;
                        srv_cli  <= gnt.cli;
                        srv_bc   <= gnt.bcast;
                        cur_upd  <= gnt.upd;
                        cur_dest <= dest_in;
                        cur_line <= line_in;
                    end
                end
                PH_HEAD: begin
                    if (flit_ready) ph <= PH_BODY;
                end
                PH_BODY: begin
                    if (flit_ready) begin
                        ph       <= PH_IDLE;
                        last_cli <= srv_cli;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle       = (ph == PH_IDLE);
    assign flit_valid = (ph == PH_HEAD) || (ph == PH_BODY);
    assign flit_eop   = (ph == PH_BODY);
    assign done       = (ph == PH_BODY) && flit_ready;

    always_comb begin
        flit_data = '0;
        if (ph == PH_HEAD) begin
            flit_data[HB_BC]             = srv_bc;
            flit_data[HB_UPD]            = cur_upd;
            flit_data[HB_CLI +: CID_W]   = srv_cli;
            flit_data[HB_DEST +: DEST_W] = cur_dest;
        end else if (ph == PH_BODY) begin
            flit_data[LINE_W-1:0] = cur_line;
        end
    end

endmodule

// File: rtl/coh_evt_cnt.sv
module coh_evt_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_upd,
    input  logic             inc_inv,
    output logic [CNT_W-1:0] upd_count,
    output logic [CNT_W-1:0] inv_count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_count <= '0;
            inv_count <= '0;
        end else begin
            if (inc_upd) upd_count <= upd_count + 1'b1;
            if (inc_inv) inv_count <= inv_count + 1'b1;
        end
    end

endmodule

// File: rtl/coh_cmd_arb.sv
module coh_cmd_arb
    import coh_arb_pkg::*;
#(
    parameter int DEST_W = 8,
    parameter int LINE_W = 26,
    parameter int FLIT_W = 40,
    parameter int CNT_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_CLI-1:0]              mc_req,
    input  logic [N_CLI-1:0]              bc_req,
    input  logic [N_CLI-1:0][DEST_W-1:0]  cli_dest,
    input  logic [N_CLI-1:0][LINE_W-1:0]  cli_line,
    input  logic                          flit_ready,
    output logic                          flit_valid,
    output logic [FLIT_W-1:0]             flit_data,
    output logic                          flit_eop,
    output logic [N_CLI-1:0]              ack_mc,
    output logic [N_CLI-1:0]              ack_bc,
    output logic [CNT_W-1:0]              upd_count,
    output logic [CNT_W-1:0]              inv_count
);

    grant_t gnt;
    cli_t   last_cli;
    cli_t   srv_cli;
    logic   srv_bc;
    logic   idle;
    logic   done;
    logic   take;

    coh_rr_pick u_pick (
        .last_cli (last_cli),
        .mc_req   (mc_req),
        .bc_req   (bc_req),
        .gnt      (gnt)
    );

    coh_flit_ser #(
        .DEST_W (DEST_W),
        .LINE_W (LINE_W),
        .FLIT_W (FLIT_W)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .gnt        (gnt),
        .dest_in    (cli_dest[gnt.cli]),
        .line_in    (cli_line[gnt.cli]),
        .flit_ready (flit_ready),
        .idle       (idle),
        .done       (done),
        .last_cli   (last_cli),
        .srv_cli    (srv_cli),
        .srv_bc     (srv_bc),
        .flit_valid (flit_valid),
        .flit_data  (flit_data),
        .flit_eop   (flit_eop)
    );

    assign take = idle && gnt.valid;

    coh_evt_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .inc_upd   (take && gnt.upd),
        .inc_inv   (take && !gnt.upd),
        .upd_count (upd_count),
        .inv_count (inv_count)
    );

    for (genvar c = 0; c < N_CLI; c++) begin : g_ack
        assign ack_mc[c] = done && !srv_bc && (srv_cli == cli_t'(c));
        assign ack_bc[c] = done &&  srv_bc && (srv_cli == cli_t'(c));
    end

endmodule

// File: rtl/coh_cmd_arb_chk.sv
module coh_cmd_arb_chk #(
    parameter int FLIT_W = 40,
    parameter int CNT_W  = 16,
    parameter int NC     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              flit_ready,
    input logic              flit_valid,
    input logic [FLIT_W-1:0] flit_data,
    input logic              flit_eop,
    input logic [NC-1:0]     ack_mc,
    input logic [NC-1:0]     ack_bc,
    input logic [CNT_W-1:0]  upd_count,
    input logic [CNT_W-1:0]  inv_count
);

    p_ack_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ack_mc, ack_bc}));

    p_ack_on_final_r8: assert property (@(posedge clk) disable iff (rst)
        (|{ack_mc, ack_bc}) |-> (flit_valid && flit_ready && flit_eop));

    p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && !flit_ready) |=> (flit_valid && $stable(flit_data) && $stable(flit_eop)));

    p_two_flits_r6: assert property (@(posedge clk) disable iff (rst)
        (flit_valid && flit_ready && !flit_eop) |=> (flit_valid && flit_eop));

    p_upd_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((upd_count == $past(upd_count)) || (upd_count == CNT_W'($past(upd_count) + 1'b1))));

    p_inv_step_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((inv_count == $past(inv_count)) || (inv_count == CNT_W'($past(inv_count) + 1'b1))));

    p_cnt_with_header_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(upd_count) || !$stable(inv_count)) |-> (flit_valid && !flit_eop));

endmodule

bind coh_cmd_arb coh_cmd_arb_chk #(
    .FLIT_W (FLIT_W),
    .CNT_W  (CNT_W),
    .NC     (coh_arb_pkg::N_CLI)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flit_ready (flit_ready),
    .flit_valid (flit_valid),
    .flit_data  (flit_data),
    .flit_eop   (flit_eop),
    .ack_mc     (ack_mc),
    .ack_bc     (ack_bc),
    .upd_count  (upd_count),
    .inv_count  (inv_count)
);

// File: tb/tb_coh_cmd_arb.sv
module tb_coh_cmd_arb;

    localparam int CLK_PERIOD = 10;
    localparam int DEST_W = 8;
    localparam int LINE_W = 26;
    localparam int FLIT_W = 40;
    localparam int CNT_W  = 16;
    localparam int NV     = 12;

    typedef struct packed {
        logic [3:0] mc;
        logic [3:0] bc;
        logic [1:0] cli;
        logic       bck;
        logic       upd;
    } vec_t;

    // walked in order from reset; expected grant follows rotating priority
    localparam vec_t TBL [NV] = '{
        '{4'b0001, 4'b0000, 2'd0, 1'b0, 1'b0},
        '{4'b0001, 4'b0000, 2'd0, 1'b0, 1'b0},
        '{4'b0011, 4'b0000, 2'd1, 1'b0, 1'b1},
        '{4'b0011, 4'b0000, 2'd0, 1'b0, 1'b0},
        '{4'b0000, 4'b1100, 2'd2, 1'b1, 1'b0},
        '{4'b0100, 4'b0100, 2'd2, 1'b0, 1'b1},
        '{4'b1000, 4'b0001, 2'd3, 1'b0, 1'b0},
        '{4'b0000, 4'b1111, 2'd0, 1'b1, 1'b0},
        '{4'b1110, 4'b0000, 2'd1, 1'b0, 1'b1},
        '{4'b1110, 4'b0000, 2'd2, 1'b0, 1'b1},
        '{4'b1110, 4'b0000, 2'd3, 1'b0, 1'b0},
        '{4'b0000, 4'b1000, 2'd3, 1'b1, 1'b0}
    };

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic [3:0]                 mc_req = '0;
    logic [3:0]                 bc_req = '0;
    logic [3:0][DEST_W-1:0]     cli_dest = '0;
    logic [3:0][LINE_W-1:0]     cli_line = '0;
    logic                       flit_ready = 1'b0;
    logic                       flit_valid;
    logic [FLIT_W-1:0]          flit_data;
    logic                       flit_eop;
    logic [3:0]                 ack_mc;
    logic [3:0]                 ack_bc;
    logic [CNT_W-1:0]           upd_count;
    logic [CNT_W-1:0]           inv_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_cmd_arb #(
        .DEST_W (DEST_W),
        .LINE_W (LINE_W),
        .FLIT_W (FLIT_W),
        .CNT_W  (CNT_W)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .mc_req     (mc_req),
        .bc_req     (bc_req),
        .cli_dest   (cli_dest),
        .cli_line   (cli_line),
        .flit_ready (flit_ready),
        .flit_valid (flit_valid),
        .flit_data  (flit_data),
        .flit_eop   (flit_eop),
        .ack_mc     (ack_mc),
        .ack_bc     (ack_bc),
        .upd_count  (upd_count),
        .inv_count  (inv_count)
    );

    function automatic logic [DEST_W-1:0] dest_of(int v, int c);
        return DEST_W'(v * 16 + c * 3 + 1);
    endfunction

    function automatic logic [LINE_W-1:0] line_of(int v, int c);
        return LINE_W'(v * 4096 + c * 257 + 5);
    endfunction

    function automatic logic [FLIT_W-1:0] hdr_of(int c, logic bck, logic upd, logic [DEST_W-1:0] d);
        logic [FLIT_W-1:0] f = '0;
        f[0] = bck;
        f[1] = upd;
        f[3:2] = 2'(c);
        f[4 +: DEST_W] = d;
        return f;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic load_fields(int v);
        for (int c = 0; c < 4; c++) begin
            cli_dest[c] = dest_of(v, c);
            cli_line[c] = line_of(v, c);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 valid after reset", 64'(flit_valid), 64'd0);
        chk("R1 upd_count reset", 64'(upd_count), 64'd0);
        chk("R1 inv_count reset", 64'(inv_count), 64'd0);
        chk("R1 acks reset", 64'({ack_mc, ack_bc}), 64'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            logic [FLIT_W-1:0] held;
            int c;
            c = int'(TBL[v].cli);
            mc_req = TBL[v].mc;
            bc_req = TBL[v].bc;
            load_fields(v);
            @(posedge clk);
            @(negedge clk);
            // R2 R3 R4 R5 header contents
            chk($sformatf("R2/R3/R4/R5 header v%0d", v), 64'(flit_data),
                64'(hdr_of(c, TBL[v].bck, TBL[v].upd, dest_of(v, c))));
            chk($sformatf("R6 header eop v%0d", v), 64'({flit_valid, flit_eop}), 64'b10);
            chk($sformatf("R8 no ack on header v%0d", v), 64'({ack_mc, ack_bc}), 64'd0);
            if (v == 0) chk("R9 inv_count at header", 64'(inv_count), 64'd1);
            if (v % 3 == 2) begin
                // R7 R10 stall with inputs changed
                held = flit_data;
                for (int c2 = 0; c2 < 4; c2++) begin
                    cli_dest[c2] = ~cli_dest[c2];
                    cli_line[c2] = ~cli_line[c2];
                end
                repeat (2) @(negedge clk);
                chk($sformatf("R7 stalled header v%0d", v), 64'({flit_valid, flit_eop, flit_data}),
                    64'({1'b1, 1'b0, held}));
            end
            flit_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R6/R10 line flit v%0d", v), 64'({flit_valid, flit_eop, flit_data}),
                64'({1'b1, 1'b1, FLIT_W'(line_of(v, c))}));
            chk($sformatf("R8 ack_mc v%0d", v), 64'(ack_mc),
                64'(TBL[v].bck ? 4'b0000 : (4'b0001 << c)));
            chk($sformatf("R8 ack_bc v%0d", v), 64'(ack_bc),
                64'(TBL[v].bck ? (4'b0001 << c) : 4'b0000));
            @(posedge clk);
            @(negedge clk);
            flit_ready = 1'b0;
            mc_req = '0;
            bc_req = '0;
            chk($sformatf("R7/R8 idle after v%0d", v), 64'({flit_valid, ack_mc, ack_bc}), 64'd0);
        end

        // R9 totals: four updates, eight invalidates
        chk("R9 upd_count total", 64'(upd_count), 64'd4);
        chk("R9 inv_count total", 64'(inv_count), 64'd8);

        // R7 no advance without ready, across a longer stall
        mc_req = 4'b0100;
        load_fields(20);
        @(posedge clk);
        @(negedge clk);
        mc_req = '0;
        repeat (4) @(negedge clk);
        chk("R7 header held without ready", 64'({flit_valid, flit_eop}), 64'b10);
        flit_ready = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        flit_ready = 1'b0;

        // R1 reset mid-run restores index 0 as top priority
        mc_req = 4'b1111;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 counters cleared", 64'({upd_count, inv_count}), 64'd0);
        chk("R1 valid low in reset", 64'(flit_valid), 64'd0);
        rst = 1'b0;
        load_fields(30);
        @(posedge clk);
        @(negedge clk);
        chk("R1 first grant after reset", 64'(flit_data), 64'(hdr_of(0, 1'b0, 1'b0, dest_of(30, 0))));
        mc_req = '0;
        flit_ready = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        flit_ready = 1'b0;
        chk("R2 idle after final", 64'(flit_valid), 64'd0);

        finish_up();
    end

endmodule